// File: doc/BRIEF.md
# Low-Power Entry and Exit Sequencer for a Pseudo-Static RAM

This block sits on the host side of a pseudo-static RAM. It owns the memory's active-high chip enable, which parks the memory in its low-power state whenever it is low. It also overrides the active-low chip enable that the access controller drives. After reset it runs the power-up wait on its own. It then accepts requests to enter and to leave the low-power state, and it stretches every mandatory delay into a whole number of clock cycles set by parameters.

While a timed phase runs, the block raises `busy` and forces the active-low enable high, so normal traffic cannot reach the memory. Once the memory is parked, `asleep` is high and only an exit request is taken. The wait after waking depends on the retention flag captured when entry was accepted. It is short when a partial-retention mode keeps data, and long after full sleep. All pins are plain level or pulse signals. No data passes through the block, so there is no valid/ready handshake and no back-pressure: a request that cannot be taken in the current state is dropped and reported on `req_rejected`.

Top module: `lp_seq_ctrl`

## Requirements
- R1: After reset, `mem_ce2` is low and `mem_ce_n` is high, with `busy` high, for exactly PWR_LOW_CYC cycles counted from reset release.
- R2: `mem_ce2` then rises, and `mem_ce_n` stays forced high with `busy` high for exactly PWR_HOLD_CYC cycles, after which `busy` falls.
- R3: In the idle state (`busy` and `asleep` both low), `mem_ce2` is high and `mem_ce_n` equals `ctrl_ce_n` in the same cycle.
- R4: An accepted `enter_req` forces `mem_ce_n` high with `mem_ce2` still high and `busy` high for exactly PRE_CYC cycles before `mem_ce2` falls.
- R5: `mem_ce2` then stays low with `busy` high for exactly DROP_CYC cycles, after which `asleep` is high and `mem_ce2` stays low until an exit request is accepted; `busy` and `asleep` are never high together.
- R6: If `retain_mode` was 0 when entry was accepted (full sleep), an accepted `exit_req` raises `mem_ce2` and holds `mem_ce_n` high with `busy` high for exactly WAKE_SLEEP_CYC cycles before returning to idle.
- R7: If `retain_mode` was 1 when entry was accepted (data retained), that wake hold lasts exactly WAKE_KEEP_CYC cycles. Changes on `retain_mode` after entry has been accepted have no effect.
- R8: `mem_ce_n` is high in every cycle in which `mem_ce2` is low, and in the cycle in which `mem_ce2` rises.
- R9: `bus_float` is high whenever the block is not idle, including the whole time `mem_ce2` is low.
- R10: `enter_req` is taken only in idle and `exit_req` only while asleep. Any other request, including every request while `busy` is high, is ignored: the phase lengths are unchanged, and `req_rejected` pulses high in the following cycle.
- R11: If both requests are high in the same cycle, the one valid for the current state is taken and the other one is flagged on `req_rejected` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the power-up wait |
| enter_req | input | 1 | Request to enter the low-power state, sampled each cycle |
| exit_req | input | 1 | Request to leave the low-power state, sampled each cycle |
| retain_mode | input | 1 | 1 when a partial-retention mode is programmed, 0 for full sleep |
| ctrl_ce_n | input | 1 | Active-low chip enable wanted by the access controller |
| mem_ce_n | output | 1 | Active-low chip enable to the memory |
| mem_ce2 | output | 1 | Active-high chip enable to the memory; low means low-power state |
| busy | output | 1 | A mandatory delay is running; normal traffic must wait |
| asleep | output | 1 | The memory is parked and an exit request will be taken |
| bus_float | output | 1 | The data bus must be kept in high impedance |
| req_rejected | output | 1 | One-cycle pulse: a request was ignored in the previous cycle |

## Verification
The bench builds the block with the cycle counts cut to 20 and 40 for power-up, 3 for entry setup, 4 for the minimum low time, 50 for the full-sleep wake and 5 for the retained wake. These values keep every phase short, so a full power-up and more than ten complete enter and exit rounds fit in a few thousand cycles. They also keep the two wake holds far enough apart that a wrong choice between them shows in the measured length. Because every phase length is a distinct small number, an off-by-one in any counter load or a swapped phase changes a measured run length.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWR_LOW  = 3'd0,  // power-up: active-high enable held low
    ST_PWR_HOLD = 3'd1,  // power-up: active-low enable held high
    ST_IDLE     = 3'd2,  // normal operation, controller owns the bus
    ST_PRE      = 3'd3,  // entry setup: active-low enable forced high
    ST_DROP     = 3'd4,  // active-high enable low, minimum hold
    ST_DOWN     = 3'd5,  // parked until an exit request
    ST_WAKE     = 3'd6   // exit hold before traffic resumes
  } lp_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lp_seq_timer.sv
module lp_seq_timer #(
  parameter int CW      = 16,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lp_seq_req.sv
module lp_seq_req
  import lp_seq_pkg::*;
(
  input  lp_state_e state,
  input  logic      enter_req,
  input  logic      exit_req,
  output logic      take_enter,
  output logic      take_exit,
  output logic      reject
);

  always_comb begin
    take_enter = enter_req && (state == ST_IDLE);
    take_exit  = exit_req  && (state == ST_DOWN);
    reject     = (enter_req && !take_enter) || (exit_req && !take_exit);
  end

endmodule

// File: rtl/lp_seq_pins.sv
module lp_seq_pins
  import lp_seq_pkg::*;
(
  input  lp_state_e state,
  input  logic      ctrl_ce_n,
  output logic      mem_ce_n,
  output logic      mem_ce2,
  output logic      busy,
  output logic      asleep,
  output logic      bus_float
);

  logic idle;

  always_comb begin
    idle      = (state == ST_IDLE);
    mem_ce2   = !((state == ST_PWR_LOW) || (state == ST_DROP) || (state == ST_DOWN));
    asleep    = (state == ST_DOWN);
    busy      = !idle && !asleep;
    bus_float = !idle;
    mem_ce_n  = idle ? ctrl_ce_n : 1'b1;
  end

endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
  import lp_seq_pkg::*;
#(
  parameter int PWR_LOW_CYC    = 5000,
  parameter int PWR_HOLD_CYC   = 30000,
  parameter int PRE_CYC        = 7,
  parameter int DROP_CYC       = 7,
  parameter int WAKE_SLEEP_CYC = 30000,
  parameter int WAKE_KEEP_CYC  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic exit_req,
  input  logic retain_mode,
  input  logic ctrl_ce_n,
  output logic mem_ce_n,
  output logic mem_ce2,
  output logic busy,
  output logic asleep,
  output logic bus_float,
  output logic req_rejected
);

  localparam int MAX_CYC = max_of(max_of(max_of(PWR_LOW_CYC, PWR_HOLD_CYC),
                                         max_of(PRE_CYC, DROP_CYC)),
                                  max_of(WAKE_SLEEP_CYC, WAKE_KEEP_CYC));
  localparam int CW = $clog2(MAX_CYC + 1);

  lp_state_e     state_q, state_d;
  logic          keep_q;
  logic          rej_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          take_enter, take_exit, reject;

  lp_seq_req u_req (
    .state      (state_q),
    .enter_req  (enter_req),
    .exit_req   (exit_req),
    .take_enter (take_enter),
    .take_exit  (take_exit),
    .reject     (reject)
  );

  lp_seq_timer #(
    .CW      (CW),
    .RST_VAL (PWR_LOW_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_PWR_LOW: if (tmr_done) begin
        state_d  = ST_PWR_HOLD;
        tmr_load = 1'b1;
        tmr_val  = CW'(PWR_HOLD_CYC - 1);
      end
      ST_PWR_HOLD: if (tmr_done) state_d = ST_IDLE;
      ST_IDLE: if (take_enter) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = CW'(PRE_CYC - 1);
      end
      ST_PRE: if (tmr_done) begin
        state_d  = ST_DROP;
        tmr_load = 1'b1;
        tmr_val  = CW'(DROP_CYC - 1);
      end
      ST_DROP: if (tmr_done) state_d = ST_DOWN;
      ST_DOWN: if (take_exit) begin
        state_d  = ST_WAKE;
        tmr_load = 1'b1;
        tmr_val  = keep_q ? CW'(WAKE_KEEP_CYC - 1) : CW'(WAKE_SLEEP_CYC - 1);
      end
      ST_WAKE: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_PWR_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR_LOW;
      keep_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rej_q   <= reject;
      if (take_enter) keep_q <= retain_mode;
    end
  end

  assign req_rejected = rej_q;

  lp_seq_pins u_pins (
    .state     (state_q),
    .ctrl_ce_n (ctrl_ce_n),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .busy      (busy),
    .asleep    (asleep),
    .bus_float (bus_float)
  );

endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk #(
  parameter int MIN_LOW = 1
) (
  input logic clk,
  input logic rst_n,
  input logic enter_req,
  input logic exit_req,
  input logic mem_ce_n,
  input logic mem_ce2,
  input logic busy,
  input logic asleep,
  input logic bus_float,
  input logic req_rejected
);

  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (mem_ce2)    low_run <= '0;
    else if (low_run != 32'hFFFF_FFFF) low_run <= low_run + 1'b1;
  end

  a_r8_ce_n_high_when_ce2_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce2 |-> mem_ce_n);

  a_r8_rise_with_ce_n_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce2) |-> mem_ce_n);

  a_r4_setup_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce2) |-> $past(mem_ce_n));

  a_r5_min_low_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce2) |-> (low_run >= 32'(MIN_LOW)));

  a_r5_busy_asleep_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && asleep));

  a_r5_asleep_ce2_low: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !mem_ce2);

  a_r9_float_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce2 |-> bus_float);

  a_r10_reject_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req_rejected |-> $past(enter_req || exit_req));

endmodule

bind lp_seq_ctrl lp_seq_chk #(
  .MIN_LOW ((DROP_CYC < PWR_LOW_CYC) ? DROP_CYC : PWR_LOW_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enter_req    (enter_req),
  .exit_req     (exit_req),
  .mem_ce_n     (mem_ce_n),
  .mem_ce2      (mem_ce2),
  .busy         (busy),
  .asleep       (asleep),
  .bus_float    (bus_float),
  .req_rejected (req_rejected)
);

// File: tb/lp_seq_ctrl_test.sv
`timescale 1ns/1ps
module lp_seq_ctrl_test;

  localparam int P_LOW   = 20;
  localparam int P_HOLD  = 40;
  localparam int P_PRE   = 3;
  localparam int P_DROP  = 4;
  localparam int P_SLEEP = 50;
  localparam int P_KEEP  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_req = 1'b0;
  logic exit_req = 1'b0;
  logic retain_mode = 1'b0;
  logic ctrl_ce_n = 1'b1;
  logic mem_ce_n, mem_ce2, busy, asleep, bus_float, req_rejected;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  pend = 1'b0;

  always #5 clk = ~clk;

  lp_seq_ctrl #(
    .PWR_LOW_CYC    (P_LOW),
    .PWR_HOLD_CYC   (P_HOLD),
    .PRE_CYC        (P_PRE),
    .DROP_CYC       (P_DROP),
    .WAKE_SLEEP_CYC (P_SLEEP),
    .WAKE_KEEP_CYC  (P_KEEP)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_req    (enter_req),
    .exit_req     (exit_req),
    .retain_mode  (retain_mode),
    .ctrl_ce_n    (ctrl_ce_n),
    .mem_ce_n     (mem_ce_n),
    .mem_ce2      (mem_ce2),
    .busy         (busy),
    .asleep       (asleep),
    .bus_float    (bus_float),
    .req_rejected (req_rejected)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wake_len(input bit keep);
    return keep ? P_KEEP : P_SLEEP;
  endfunction

  // Consumes samples of one busy phase, starting at the current negedge.
  // Leaves the bench at the first sample of the following phase.
  task automatic run_phase(input string tag, input bit want_ce2, input int exp_len);
    int  n = 0;
    bit  stop = 1'b0;
    while (!stop && n < 100000) begin
      if (busy && (mem_ce2 == want_ce2)) begin
        chk(mem_ce_n == 1'b1, "R8 ce_n forced high", int'(mem_ce_n), 1);
        chk(bus_float == 1'b1, "R9 float while busy", int'(bus_float), 1);
        n++;
        enter_req = ($urandom_range(0, 3) == 0);
        exit_req  = ($urandom_range(0, 3) == 0);
        ctrl_ce_n = 1'($urandom_range(0, 1));
        pend      = enter_req | exit_req;
        @(negedge clk);
        chk(req_rejected == pend, "R10 reject while busy", int'(req_rejected), int'(pend));
      end else begin
        stop      = 1'b1;
        enter_req = 1'b0;
        exit_req  = 1'b0;
        pend      = 1'b0;
      end
    end
    chk(n == exp_len, tag, n, exp_len);
  endtask

  task automatic idle_checks(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      ctrl_ce_n = 1'($urandom_range(0, 1));
      #1;
      chk(mem_ce_n == ctrl_ce_n, "R3 ce_n passthrough", int'(mem_ce_n), int'(ctrl_ce_n));
      chk(mem_ce2 && !busy && !asleep && !bus_float, "R3 idle outputs",
          int'({mem_ce2, busy, asleep, bus_float}), 8);
      @(negedge clk);
    end
  endtask

  task automatic do_round(input bit keep, input bit both);
    retain_mode = keep;
    enter_req   = 1'b1;
    exit_req    = both;
    @(negedge clk);
    enter_req   = 1'b0;
    exit_req    = 1'b0;
    chk(req_rejected == both, "R11 simultaneous at entry", int'(req_rejected), int'(both));
    retain_mode = ~keep;  // must be ignored: mode was captured at entry (R7)
    run_phase("R4 setup length", 1'b1, P_PRE);
    run_phase("R5 low hold length", 1'b0, P_DROP);
    chk(asleep && !mem_ce2 && !busy, "R5 parked", int'({asleep, mem_ce2, busy}), 4);
    chk(bus_float && mem_ce_n, "R9 float while parked", int'({bus_float, mem_ce_n}), 3);
    for (int i = 0; i < int'($urandom_range(0, 4)); i++) @(negedge clk);
    enter_req = 1'b1;
    @(negedge clk);
    enter_req = 1'b0;
    chk(req_rejected == 1'b1, "R10 enter while asleep", int'(req_rejected), 1);
    chk(asleep && !mem_ce2, "R10 still parked", int'({asleep, mem_ce2}), 2);
    exit_req  = 1'b1;
    enter_req = both;
    @(negedge clk);
    exit_req  = 1'b0;
    enter_req = 1'b0;
    chk(req_rejected == both, "R11 simultaneous at exit", int'(req_rejected), int'(both));
    chk(mem_ce2 && mem_ce_n, "R8 ce2 rises with ce_n high", int'({mem_ce2, mem_ce_n}), 3);
    run_phase(keep ? "R7 retained wake length" : "R6 sleep wake length", 1'b1, wake_len(keep));
    idle_checks(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #12;
    chk(!mem_ce2 && mem_ce_n && busy && !asleep, "R1 reset state",
        int'({mem_ce2, mem_ce_n, busy, asleep}), 6);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    run_phase("R1 power-up low length", 1'b0, P_LOW);
    run_phase("R2 power-up hold length", 1'b1, P_HOLD);
    chk(!busy && mem_ce2, "R2 idle after power-up", int'({busy, mem_ce2}), 1);
    idle_checks(6);

    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    chk(req_rejected == 1'b1, "R10 exit while idle", int'(req_rejected), 1);
    chk(!busy && !asleep && mem_ce2, "R10 idle kept", int'({busy, asleep, mem_ce2}), 1);
    @(negedge clk);
    chk(req_rejected == 1'b0, "R10 pulse is one cycle", int'(req_rejected), 0);

    do_round(1'b0, 1'b0);
    do_round(1'b1, 1'b0);
    do_round(1'b1, 1'b1);
    do_round(1'b0, 1'b1);
    for (int r = 0; r < 8; r++) begin
      do_round(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      idle_checks(int'($urandom_range(1, 4)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule